// File: doc/BRIEF.md
# Byte-Swap Scratch Register with Masked Status Lights

This block is a small AXI4-Lite slave that a host uses to check that its register path works. The host writes a 32-bit scratch word, and every read of that word comes back with its bytes in reverse order. A correct swap on read-back shows that addressing, byte lanes and data ordering all work end to end.

The low 16 bits of the scratch word are also visible as a read-only mirror at a second address. The same 16 bits drive a 16-bit light output. Each light bit is gated by the matching bit of an external 16-bit switch input, so the switches choose which mirrored bits reach the lights. Any other address returns an error response. The block accepts one write and one read at a time. It lowers its ready signals while a response waits for the host.

Top module: `axil_swap_shadow`

## Requirements
- R1: While `rst_n` is low, the scratch word clears to zero, `led_o` is zero, `s_bvalid` and `s_rvalid` are low, and `s_awready`, `s_wready` and `s_arready` are high.
- R2: A write to byte address 0x500 stores the write data without reordering. Strobe bit i enables bits 8i+7:8i, and bytes whose strobe bit is clear keep their old value. The response is OKAY (2'b00).
- R3: A read of 0x500 returns the stored word byte-reversed: rdata[31:24]=stored[7:0], rdata[23:16]=stored[15:8], rdata[15:8]=stored[23:16], rdata[7:0]=stored[31:24]. The response is OKAY.
- R4: A read of 0x504 returns stored[15:0] in rdata[15:0], with rdata[31:16] zero. The response is OKAY.
- R5: At every moment, `led_o` equals stored[15:0] ANDed bit by bit with `sw_mask_i`. For example, a mask of 0x00FF passes only the low 8 bits.
- R6: A write to 0x504 completes with OKAY and leaves the scratch word unchanged.
- R7: Any address other than exactly 0x500 or 0x504 gets SLVERR (2'b10). Such a write changes nothing, and such a read returns zero data.
- R8: The write address and write data may be accepted in either order or in the same cycle. `s_bvalid` rises on the clock edge after the later of the two is accepted. Once asserted, `s_bvalid` and `s_rvalid` stay high with stable response and data until their ready is seen high.
- R9: `s_awready` is low from the acceptance of a write address until its B handshake completes. The same holds for `s_wready` with the write data. `s_arready` is low while `s_rvalid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with `clk` |
| s_awaddr | input | 12 | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte enables |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 12 | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| sw_mask_i | input | 16 | Per-bit gate for the light output |
| led_o | output | 16 | Mirrored low half of the scratch word, gated by the mask |

## Verification
The bench uses the default parameters: a 12-bit address, a 32-bit data word and a 16-bit light width. With these values the full switch mask can be swept, and all four byte lanes of the swap can be seen with distinct byte values. The 12-bit address also leaves room for unmapped addresses near and far from the two mapped ones. Writes are sent address-first, data-first and with both together, under partial strobes and with response backpressure. A reset in the middle of the run checks that the lights clear with the scratch word.

// File: rtl/axil_swap_pkg.sv
package axil_swap_pkg;

  typedef logic [1:0] axresp_t;

  localparam axresp_t RESP_OKAY   = 2'b00;
  localparam axresp_t RESP_SLVERR = 2'b10;

endpackage

// File: rtl/swap_wr_chan.sv
module swap_wr_chan
  import axil_swap_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   awaddr_i,
  input  logic                awvalid_i,
  output logic                awready_o,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [DATA_W/8-1:0] wstrb_i,
  input  logic                wvalid_i,
  output logic                wready_o,
  output axresp_t             bresp_o,
  output logic                bvalid_o,
  input  logic                bready_i,
  output logic                commit_o,
  output logic [ADDR_W-1:0]   commit_addr_o,
  output logic [DATA_W-1:0]   commit_data_o,
  output logic [DATA_W/8-1:0] commit_strb_o,
  input  logic                commit_ok_i
);

  localparam int STRB_W = DATA_W / 8;

  logic              aw_held_q, aw_held_d;
  logic              w_held_q,  w_held_d;
  logic              bvalid_q,  bvalid_d;
  axresp_t           bresp_q,   bresp_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [STRB_W-1:0] strb_q;
  logic              addr_en, data_en, resp_en;

  assign awready_o = !aw_held_q && !bvalid_q;
  assign wready_o  = !w_held_q  && !bvalid_q;
  assign bvalid_o  = bvalid_q;
  assign bresp_o   = bresp_q;

  assign commit_o      = aw_held_q && w_held_q && !bvalid_q;
  assign commit_addr_o = addr_q;
  assign commit_data_o = data_q;
  assign commit_strb_o = strb_q;

  // next-state
  always_comb begin
    aw_held_d = aw_held_q;
    w_held_d  = w_held_q;
    bvalid_d  = bvalid_q;
    bresp_d   = bresp_q;
    addr_en   = 1'b0;
    data_en   = 1'b0;
    resp_en   = 1'b0;
    if (bvalid_q) begin
      if (bready_i) bvalid_d = 1'b0;
    end else if (commit_o) begin
      bvalid_d  = 1'b1;
      resp_en   = 1'b1;
      bresp_d   = commit_ok_i ? RESP_OKAY : RESP_SLVERR;
      aw_held_d = 1'b0;
      w_held_d  = 1'b0;
    end else begin
      if (awvalid_i && awready_o) begin
        aw_held_d = 1'b1;
        addr_en   = 1'b1;
      end
      if (wvalid_i && wready_o) begin
        w_held_d = 1'b1;
        data_en  = 1'b1;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_held_q <= 1'b0;
      w_held_q  <= 1'b0;
      bvalid_q  <= 1'b0;
      bresp_q   <= RESP_OKAY;
    end else begin
      aw_held_q <= aw_held_d;
      w_held_q  <= w_held_d;
      bvalid_q  <= bvalid_d;
      if (resp_en) bresp_q <= bresp_d;
    end
  end

  // captured request fields, enabled only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      strb_q <= '0;
    end else begin
      if (addr_en) addr_q <= awaddr_i;
      if (data_en) begin
        data_q <= wdata_i;
        strb_q <= wstrb_i;
      end
    end
  end

  assert_b_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid_q && !bready_i) |=> (bvalid_q && $stable(bresp_q)));

  assert_b_after_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bvalid_q) |-> $past(aw_held_q && w_held_q));

  assert_aw_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid_i && awready_o) |=> !awready_o);

endmodule

// File: rtl/swap_rd_chan.sv
module swap_rd_chan
  import axil_swap_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [DATA_W-1:0] rdata_o,
  output axresp_t           rresp_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  output logic [ADDR_W-1:0] look_addr_o,
  input  logic [DATA_W-1:0] look_data_i,
  input  logic              look_ok_i
);

  logic              rvalid_q, rvalid_d;
  logic [DATA_W-1:0] rdata_q;
  axresp_t           rresp_q;
  logic              load_en;

  assign arready_o   = !rvalid_q;
  assign rvalid_o    = rvalid_q;
  assign rdata_o     = rdata_q;
  assign rresp_o     = rresp_q;
  assign look_addr_o = araddr_i;

  // next-state
  always_comb begin
    rvalid_d = rvalid_q;
    load_en  = 1'b0;
    if (rvalid_q) begin
      if (rready_i) rvalid_d = 1'b0;
    end else if (arvalid_i) begin
      rvalid_d = 1'b1;
      load_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
      rresp_q  <= RESP_OKAY;
    end else begin
      rvalid_q <= rvalid_d;
      if (load_en) begin
        rdata_q <= look_data_i;
        rresp_q <= look_ok_i ? RESP_OKAY : RESP_SLVERR;
      end
    end
  end

  assert_r_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid_q && !rready_i) |=> (rvalid_q && $stable(rdata_q) && $stable(rresp_q)));

  assert_ar_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (arvalid_i && arready_o) |=> !arready_o);

endmodule

// File: rtl/swap_reg_core.sv
module swap_reg_core #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int LIGHT_W = 16,
  parameter logic [ADDR_W-1:0] SCR_OFFS = 12'h500,
  parameter logic [ADDR_W-1:0] SHD_OFFS = 12'h504
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [DATA_W/8-1:0] wr_strb_i,
  output logic                wr_ok_o,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic                rd_ok_o,
  input  logic [LIGHT_W-1:0]  sw_mask_i,
  output logic [LIGHT_W-1:0]  led_o
);

  localparam int NBYTES = DATA_W / 8;

  logic [DATA_W-1:0]  scratch_q;
  logic [DATA_W-1:0]  swapped;
  logic [DATA_W-1:0]  shadow_ext;
  logic [LIGHT_W-1:0] shadow;
  logic               wr_hit_scr, wr_hit_shd;
  logic               rd_hit_scr, rd_hit_shd;

  assign wr_hit_scr = (wr_addr_i == SCR_OFFS);
  assign wr_hit_shd = (wr_addr_i == SHD_OFFS);
  assign wr_ok_o    = wr_hit_scr || wr_hit_shd;

  assign rd_hit_scr = (rd_addr_i == SCR_OFFS);
  assign rd_hit_shd = (rd_addr_i == SHD_OFFS);
  assign rd_ok_o    = rd_hit_scr || rd_hit_shd;

  // per-lane storage with its own clock enable
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic lane_en;
    assign lane_en = wr_en_i && wr_hit_scr && wr_strb_i[b];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        scratch_q[8*b +: 8] <= 8'h00;
      end else if (lane_en) begin
        scratch_q[8*b +: 8] <= wr_data_i[8*b +: 8];
      end
    end
    // lane b of the read view comes from the mirrored lane
    assign swapped[8*b +: 8] = scratch_q[8*(NBYTES-1-b) +: 8];
  end

  assign shadow = scratch_q[LIGHT_W-1:0];

  always_comb begin
    shadow_ext                = '0;
    shadow_ext[LIGHT_W-1:0]   = shadow;
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_hit_scr)      rd_data_o = swapped;
    else if (rd_hit_shd) rd_data_o = shadow_ext;
  end

  assign led_o = shadow & sw_mask_i;

  assert_shadow_ro_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_hit_shd) |=> $stable(scratch_q));

  assert_shadow_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit_shd |-> (rd_data_o[DATA_W-1:LIGHT_W] == '0));

endmodule

// File: rtl/axil_swap_shadow.sv
module axil_swap_shadow
  import axil_swap_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int LIGHT_W = 16,
  parameter logic [ADDR_W-1:0] SCR_OFFS = 12'h500,
  parameter logic [ADDR_W-1:0] SHD_OFFS = 12'h504
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  input  logic                s_wvalid,
  output logic                s_wready,
  output logic [1:0]          s_bresp,
  output logic                s_bvalid,
  input  logic                s_bready,
  input  logic [ADDR_W-1:0]   s_araddr,
  input  logic                s_arvalid,
  output logic                s_arready,
  output logic [DATA_W-1:0]   s_rdata,
  output logic [1:0]          s_rresp,
  output logic                s_rvalid,
  input  logic                s_rready,
  input  logic [LIGHT_W-1:0]  sw_mask_i,
  output logic [LIGHT_W-1:0]  led_o
);

  logic                commit;
  logic [ADDR_W-1:0]   commit_addr;
  logic [DATA_W-1:0]   commit_data;
  logic [DATA_W/8-1:0] commit_strb;
  logic                commit_ok;
  logic [ADDR_W-1:0]   look_addr;
  logic [DATA_W-1:0]   look_data;
  logic                look_ok;

  swap_wr_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk           (clk),
    .rst_n         (rst_n),
    .awaddr_i      (s_awaddr),
    .awvalid_i     (s_awvalid),
    .awready_o     (s_awready),
    .wdata_i       (s_wdata),
    .wstrb_i       (s_wstrb),
    .wvalid_i      (s_wvalid),
    .wready_o      (s_wready),
    .bresp_o       (s_bresp),
    .bvalid_o      (s_bvalid),
    .bready_i      (s_bready),
    .commit_o      (commit),
    .commit_addr_o (commit_addr),
    .commit_data_o (commit_data),
    .commit_strb_o (commit_strb),
    .commit_ok_i   (commit_ok)
  );

  swap_rd_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .araddr_i    (s_araddr),
    .arvalid_i   (s_arvalid),
    .arready_o   (s_arready),
    .rdata_o     (s_rdata),
    .rresp_o     (s_rresp),
    .rvalid_o    (s_rvalid),
    .rready_i    (s_rready),
    .look_addr_o (look_addr),
    .look_data_i (look_data),
    .look_ok_i   (look_ok)
  );

  swap_reg_core #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .LIGHT_W  (LIGHT_W),
    .SCR_OFFS (SCR_OFFS),
    .SHD_OFFS (SHD_OFFS)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (commit),
    .wr_addr_i (commit_addr),
    .wr_data_i (commit_data),
    .wr_strb_i (commit_strb),
    .wr_ok_o   (commit_ok),
    .rd_addr_i (look_addr),
    .rd_data_o (look_data),
    .rd_ok_o   (look_ok),
    .sw_mask_i (sw_mask_i),
    .led_o     (led_o)
  );

  assert_led_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((led_o & ~sw_mask_i) == '0));

  assert_err_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && s_rresp == RESP_SLVERR) |-> (s_rdata == '0));

  assert_commit_idle_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !s_bvalid);

endmodule

// File: tb/axil_swap_shadow_tb_top.sv
module axil_swap_shadow_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] s_awaddr = '0;
  logic        s_awvalid = 1'b0;
  logic        s_awready;
  logic [31:0] s_wdata = '0;
  logic [3:0]  s_wstrb = '0;
  logic        s_wvalid = 1'b0;
  logic        s_wready;
  logic [1:0]  s_bresp;
  logic        s_bvalid;
  logic        s_bready = 1'b0;
  logic [11:0] s_araddr = '0;
  logic        s_arvalid = 1'b0;
  logic        s_arready;
  logic [31:0] s_rdata;
  logic [1:0]  s_rresp;
  logic        s_rvalid;
  logic        s_rready = 1'b0;
  logic [15:0] sw_mask_i = 16'hFFFF;
  logic [15:0] led_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  axil_swap_shadow dut_i (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .sw_mask_i(sw_mask_i), .led_o(led_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_scr;
  bit          m_aw, m_w, m_b, m_r;
  logic [11:0] m_addr;
  logic [31:0] m_data;
  logic [3:0]  m_strb;
  logic [1:0]  m_bresp, m_rresp;
  logic [31:0] m_rdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_scr = 0; m_aw = 0; m_w = 0; m_b = 0; m_r = 0;
      m_bresp = 0; m_rresp = 0; m_rdata = 0; m_addr = 0; m_data = 0; m_strb = 0;
    end else begin
      // read side uses the word as it stood before this edge
      if (m_r) begin
        if (s_rready) m_r = 0;
      end else if (s_arvalid) begin
        m_r = 1;
        if (s_araddr == 12'h500) begin
          m_rdata = {m_scr[7:0], m_scr[15:8], m_scr[23:16], m_scr[31:24]};
          m_rresp = 2'b00;
        end else if (s_araddr == 12'h504) begin
          m_rdata = {16'h0, m_scr[15:0]};
          m_rresp = 2'b00;
        end else begin
          m_rdata = 0;
          m_rresp = 2'b10;
        end
      end
      if (m_b) begin
        if (s_bready) m_b = 0;
      end else if (m_aw && m_w) begin
        if (m_addr == 12'h500)
          for (int k = 0; k < 4; k++) if (m_strb[k]) m_scr[8*k +: 8] = m_data[8*k +: 8];
        m_bresp = (m_addr == 12'h500 || m_addr == 12'h504) ? 2'b00 : 2'b10;
        m_b = 1; m_aw = 0; m_w = 0;
      end else begin
        if (s_awvalid && !m_aw) begin m_aw = 1; m_addr = s_awaddr; end
        if (s_wvalid && !m_w) begin m_w = 1; m_data = s_wdata; m_strb = s_wstrb; end
      end
    end
  end

  // compare every cycle, a quarter period after the rising edge
  always @(posedge clk) begin
    #5;
    chk("R9", "awready", {31'h0, s_awready}, {31'h0, !m_aw && !m_b});
    chk("R9", "wready",  {31'h0, s_wready},  {31'h0, !m_w && !m_b});
    chk("R9", "arready", {31'h0, s_arready}, {31'h0, !m_r});
    chk("R8", "bvalid",  {31'h0, s_bvalid},  {31'h0, m_b});
    chk("R8", "rvalid",  {31'h0, s_rvalid},  {31'h0, m_r});
    if (m_b) chk("R7", "bresp", {30'h0, s_bresp}, {30'h0, m_bresp});
    if (m_r) begin
      chk("R3", "rdata", s_rdata, m_rdata);
      chk("R7", "rresp", {30'h0, s_rresp}, {30'h0, m_rresp});
    end
    chk("R5", "led", {16'h0, led_o}, {16'h0, m_scr[15:0] & sw_mask_i});
  end

  // ---------------- drivers ----------------
  // order: 0 together, 1 address first, 2 data first
  task automatic do_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] st,
                          input int order, input int bdelay, output logic [1:0] resp);
    bit aw_done = 0, w_done = 0, a_hs, w_hs;
    @(negedge clk);
    s_awaddr = a; s_wdata = d; s_wstrb = st;
    if (order != 2) s_awvalid = 1;
    if (order != 1) s_wvalid = 1;
    while (!(aw_done && w_done)) begin
      a_hs = s_awvalid && s_awready;
      w_hs = s_wvalid && s_wready;
      @(posedge clk); @(negedge clk);
      if (a_hs) begin aw_done = 1; s_awvalid = 0; end
      if (w_hs) begin w_done = 1; s_wvalid = 0; end
      if (order == 1 && aw_done && !w_done) s_wvalid = 1;
      if (order == 2 && w_done && !aw_done) s_awvalid = 1;
    end
    while (!s_bvalid) begin @(posedge clk); @(negedge clk); end
    repeat (bdelay) begin @(posedge clk); @(negedge clk); end
    resp = s_bresp;
    s_bready = 1;
    @(posedge clk); @(negedge clk);
    s_bready = 0;
  endtask

  task automatic do_read(input logic [11:0] a, input int rdelay,
                         output logic [31:0] d, output logic [1:0] resp);
    @(negedge clk);
    s_araddr = a; s_arvalid = 1;
    while (!s_arready) begin @(posedge clk); @(negedge clk); end
    @(posedge clk); @(negedge clk);
    s_arvalid = 0;
    repeat (rdelay) begin @(posedge clk); @(negedge clk); end
    d = s_rdata; resp = s_rresp;
    s_rready = 1;
    @(posedge clk); @(negedge clk);
    s_rready = 0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic [1:0]  rs, bs;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk("R1", "led in reset", {16'h0, led_o}, 32'h0);
    chk("R1", "awready in reset", {31'h0, s_awready}, 32'h1);
    chk("R1", "bvalid in reset", {31'h0, s_bvalid}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    // R2/R3: full write, swapped read-back
    do_write(12'h500, 32'h11223344, 4'hF, 0, 0, bs);
    chk("R2", "bresp full write", {30'h0, bs}, 32'h0);
    do_read(12'h500, 0, rd, rs);
    chk("R3", "swapped read", rd, 32'h44332211);
    chk("R3", "rresp", {30'h0, rs}, 32'h0);

    // R2: partial strobes, address first, B backpressure
    do_write(12'h500, 32'hAABBCCDD, 4'b0101, 1, 3, bs);
    chk("R2", "bresp partial", {30'h0, bs}, 32'h0);
    do_read(12'h500, 2, rd, rs);
    chk("R2", "partial merge", rd, 32'hDD33BB11);

    // R4: shadow read
    do_read(12'h504, 0, rd, rs);
    chk("R4", "shadow read", rd, 32'h000033DD);
    chk("R4", "shadow rresp", {30'h0, rs}, 32'h0);

    // R5: mask patterns
    sw_mask_i = 16'h00FF; @(negedge clk);
    chk("R5", "led low byte", {16'h0, led_o}, 32'h000000DD);
    sw_mask_i = 16'h0000; @(negedge clk);
    chk("R5", "led all off", {16'h0, led_o}, 32'h0);
    sw_mask_i = 16'hF0F0; @(negedge clk);
    chk("R5", "led nibbles", {16'h0, led_o}, 32'h000030D0);
    sw_mask_i = 16'hFFFF;

    // R6: shadow write ignored, data first
    do_write(12'h504, 32'h0000FFFF, 4'hF, 2, 0, bs);
    chk("R6", "shadow write resp", {30'h0, bs}, 32'h0);
    do_read(12'h500, 0, rd, rs);
    chk("R6", "scratch kept", rd, 32'hDD33BB11);

    // R7: unmapped accesses
    do_write(12'h508, 32'h12345678, 4'hF, 0, 1, bs);
    chk("R7", "unmapped write resp", {30'h0, bs}, 32'h2);
    do_write(12'h501, 32'h12345678, 4'hF, 1, 0, bs);
    chk("R7", "misaligned write resp", {30'h0, bs}, 32'h2);
    do_read(12'h010, 0, rd, rs);
    chk("R7", "unmapped read data", rd, 32'h0);
    chk("R7", "unmapped read resp", {30'h0, rs}, 32'h2);
    do_read(12'h500, 0, rd, rs);
    chk("R7", "scratch after bad writes", rd, 32'hDD33BB11);

    // R8: write and read in flight together
    fork
      do_write(12'h500, 32'hCAFE0102, 4'hF, 2, 2, bs);
      do_read(12'h504, 1, rd, rs);
    join
    chk("R8", "overlap write resp", {30'h0, bs}, 32'h0);
    do_read(12'h500, 0, rd, rs);
    chk("R8", "overlap stored", rd, 32'h0201FECA);

    // R1: reset in the middle clears the lights
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R1", "led after reset", {16'h0, led_o}, 32'h0);
    rst_n = 1;
    do_read(12'h500, 0, rd, rs);
    chk("R1", "scratch after reset", rd, 32'h0);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule